// File: doc/BRIEF.md
# AUX Channel Transaction Sequencer

This block carries out a single DisplayPort AUX request from start to finish against a lower-level AUX engine. The engine does the electrical signalling. A client supplies the following, then pulses `start`:

- a 4-bit command code;
- a 20-bit address;
- a byte count from 1 to 16;
- up to 16 write bytes.

The sequencer then runs these steps in order:

1. It claims the channel and checks that the claim was granted.
2. It polls the engine for readiness, a bounded number of times.
3. It programs the address, command, length and, for writes, the data.
4. It fires the request. If the sink replies DEFER, it fires the request again.
5. On a read, it checks the returned byte count.
6. It releases the channel.

A single `done` pulse reports the outcome. It carries an error class, the last raw reply code and, on a good read, the received bytes.

All waits are timer counts derived from the clock frequency in MHz and the wait lengths in microseconds. A bench can make them short by setting a small clock frequency.

Top module: `aux_txn_seq`

## Requirements
- R1: On start, `claim_req` rises; if `claim_grant` is low one cycle later, the transaction ends with error class IO (code 1), and no reset or trigger strobe is issued.
- R2: The ready flag is sampled at most READY_POLLS (3) times, with a POLL_US wait between samples; if it is never seen high, the error class is BUSY (code 2) and no strobe is issued.
- R3: Bit 0 of the command marks a read. A write (bit 0 = 0) presents its data on `eng_wdata`; a read leaves `eng_wdata` at its previous value.
- R4: `eng_addr` and `eng_cmd` take the requested values, and `eng_len` takes the byte count minus one.
- R5: Every attempt pulses `eng_rst` for one cycle, then raises `eng_trig` until `eng_trig_ack`. If no acknowledge arrives within TRIG_TIMEOUT cycles, the error class is BUSY.
- R6: After each acknowledge and a SETTLE_US wait, the reply is sampled. The attempt is repeated only when `eng_reply[1:0]` is 2'b10 (DEFER), up to MAX_ATTEMPTS (16) attempts in total.
- R7: If every one of the 16 attempts returns DEFER, the error class is REMOTE (code 3), and `reply` reads back the DEFER code.
- R8: On a read, a returned count that differs from the requested count gives error class REMOTE, and `rdata` stays all zero. On a good read, `rdata` carries `eng_rdata`.
- R9: Every exit path drops `claim_req` before `done`. If `claim_grant` is still high after the release, the error class becomes IO. A SETTLE_US tail wait precedes `done`.
- R10: `done` is a one-cycle pulse with `err` and `reply` valid in that cycle. Error classes are NONE = 0, IO = 1, BUSY = 2, REMOTE = 3. Non-DEFER replies such as NACK end with error NONE and the raw code.
- R11: A `start` while `busy` is high is ignored: it neither restarts nor changes the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| cmd | input | 4 | Command code, bit 0 = read |
| addr | input | 20 | Target address |
| nbytes | input | 5 | Byte count, 1 to 16 |
| wdata | input | 128 | Write bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Error class, valid with done |
| reply | output | 4 | Last sampled raw reply code |
| rdata | output | 128 | Read bytes on a good read, else zero |
| claim_req | output | 1 | Channel claim request |
| claim_grant | input | 1 | Channel grant status |
| eng_ready | input | 1 | Engine ready flag |
| eng_rst | output | 1 | Per-attempt reset strobe |
| eng_trig | output | 1 | Request trigger, held until acknowledged |
| eng_trig_ack | input | 1 | Engine has taken the trigger |
| eng_cmd | output | 4 | Programmed command |
| eng_addr | output | 20 | Programmed address |
| eng_len | output | 4 | Programmed length (count minus one) |
| eng_wdata | output | 128 | Programmed write data |
| eng_reply | input | 4 | Engine reply status |
| eng_rcount | input | 5 | Bytes received by the engine |
| eng_rdata | input | 128 | Bytes received by the engine |

## Verification
The assertions watch, on every cycle, the strobe ordering at the engine side and the protocol around them:

- no strobe occurs outside a held claim;
- a reset pulse comes before each trigger rise;
- the claim is dropped by the time `done` fires;
- `done` lasts one cycle;
- a claim only starts from an idle cycle with `start`.

Some behaviour needs controlled engine responses and is shown only by the bench scenarios:

- the retry count under a given number of DEFER replies;
- the error class chosen on each failure path;
- the read count check and data delivery;
- the write data left untouched by a read;
- the minimum duration imposed by the settle and tail waits.

// File: rtl/aux_seq_pkg.sv
`timescale 1ns/1ps
package aux_seq_pkg;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_IO     = 2'd1,
        ERR_BUSY   = 2'd2,
        ERR_REMOTE = 2'd3
    } aux_err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLAIM,
        S_POLL,
        S_POLL_WAIT,
        S_LOAD,
        S_RST,
        S_TRIG,
        S_SETTLE,
        S_SAMPLE,
        S_REL,
        S_TAIL
    } seq_state_e;

    localparam logic [1:0] REPLY_DEFER = 2'b10;

endpackage

// File: rtl/aux_wait_timer.sv
`timescale 1ns/1ps
module aux_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/aux_reply_eval.sv
`timescale 1ns/1ps
module aux_reply_eval #(
    parameter int CW = 5
) (
    input  logic [3:0]    reply_code,
    input  logic          is_read,
    input  logic [CW-1:0] got_count,
    input  logic [CW-1:0] want_count,
    output logic          is_defer,
    output logic          count_bad
);
    import aux_seq_pkg::*;

    assign is_defer  = (reply_code[1:0] == REPLY_DEFER);
    assign count_bad = is_read && (got_count != want_count);
endmodule

// File: rtl/aux_txn_seq.sv
`timescale 1ns/1ps
module aux_txn_seq #(
    parameter int CLK_MHZ      = 50,
    parameter int POLL_US      = 100,
    parameter int SETTLE_US    = 400,
    parameter int TRIG_TIMEOUT = 1024,
    parameter int READY_POLLS  = 3,
    parameter int MAX_ATTEMPTS = 16,
    parameter int MAX_BYTES    = 16,
    parameter int ADDR_W       = 20,
    localparam int DW          = 8 * MAX_BYTES,
    localparam int CW          = $clog2(MAX_BYTES + 1),
    localparam int LW          = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     nbytes,
    input  logic [DW-1:0]     wdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err,
    output logic [3:0]        reply,
    output logic [DW-1:0]     rdata,
    output logic              claim_req,
    input  logic              claim_grant,
    input  logic              eng_ready,
    output logic              eng_rst,
    output logic              eng_trig,
    input  logic              eng_trig_ack,
    output logic [3:0]        eng_cmd,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [LW-1:0]     eng_len,
    output logic [DW-1:0]     eng_wdata,
    input  logic [3:0]        eng_reply,
    input  logic [CW-1:0]     eng_rcount,
    input  logic [DW-1:0]     eng_rdata
);
    import aux_seq_pkg::*;

    localparam int POLL_CYC   = CLK_MHZ * POLL_US;
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int MAX_A      = (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
    localparam int MAX_WAIT   = (MAX_A > TRIG_TIMEOUT) ? MAX_A : TRIG_TIMEOUT;
    localparam int TW         = $clog2(MAX_WAIT + 1);
    localparam int PW         = $clog2(READY_POLLS + 1);
    localparam int AW         = $clog2(MAX_ATTEMPTS + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [PW-1:0]     polls;
        logic [AW-1:0]     attempts;
        logic [3:0]        r_cmd;
        logic [ADDR_W-1:0] r_addr;
        logic [CW-1:0]     r_n;
        logic [DW-1:0]     r_wdata;
        logic              claim;
        logic              eng_rst;
        logic              eng_trig;
        logic [3:0]        eng_cmd;
        logic [ADDR_W-1:0] eng_addr;
        logic [LW-1:0]     eng_len;
        logic [DW-1:0]     eng_wdata;
        aux_err_e          err;
        logic [3:0]        reply;
        logic [DW-1:0]     rdata;
        logic              done;
    } seq_t;

    seq_t d, q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          is_defer;
    logic          count_bad;

    aux_wait_timer #(.W(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    aux_reply_eval #(.CW(CW)) i_eval (
        .reply_code (eng_reply),
        .is_read    (q.r_cmd[0]),
        .got_count  (eng_rcount),
        .want_count (q.r_n),
        .is_defer   (is_defer),
        .count_bad  (count_bad)
    );

    always_comb begin
        d          = q;
        d.eng_rst  = 1'b0;
        d.done     = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        case (q.state)
            S_IDLE: if (start) begin
                d.state    = S_CLAIM;
                d.claim    = 1'b1;
                d.r_cmd    = cmd;
                d.r_addr   = addr;
                d.r_n      = nbytes;
                d.r_wdata  = wdata;
                d.err      = ERR_NONE;
                d.reply    = '0;
                d.rdata    = '0;
                d.polls    = '0;
                d.attempts = '0;
            end
            S_CLAIM: begin
                if (claim_grant) begin
                    d.state = S_POLL;
                end else begin
                    d.err   = ERR_IO;
                    d.claim = 1'b0;
                    d.state = S_REL;
                end
            end
            S_POLL: begin
                if (eng_ready) begin
                    d.state = S_LOAD;
                end else if (q.polls == PW'(READY_POLLS - 1)) begin
                    d.err   = ERR_BUSY;
                    d.claim = 1'b0;
                    d.state = S_REL;
                end else begin
                    d.polls  = q.polls + 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(POLL_CYC);
                    d.state  = S_POLL_WAIT;
                end
            end
            S_POLL_WAIT: if (tmr_exp) d.state = S_POLL;
            S_LOAD: begin
                d.eng_addr = q.r_addr;
                d.eng_cmd  = q.r_cmd;
                d.eng_len  = LW'(q.r_n - 1'b1);
                if (!q.r_cmd[0]) d.eng_wdata = q.r_wdata;
                d.eng_rst  = 1'b1;
                d.state    = S_RST;
            end
            S_RST: begin
                d.eng_trig = 1'b1;
                tmr_load   = 1'b1;
                tmr_val    = TW'(TRIG_TIMEOUT);
                d.state    = S_TRIG;
            end
            S_TRIG: begin
                if (eng_trig_ack) begin
                    d.eng_trig = 1'b0;
                    d.attempts = q.attempts + 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(SETTLE_CYC);
                    d.state    = S_SETTLE;
                end else if (tmr_exp) begin
                    d.eng_trig = 1'b0;
                    d.err      = ERR_BUSY;
                    d.claim    = 1'b0;
                    d.state    = S_REL;
                end
            end
            S_SETTLE: if (tmr_exp) d.state = S_SAMPLE;
            S_SAMPLE: begin
                d.reply = eng_reply;
                if (is_defer && (q.attempts != AW'(MAX_ATTEMPTS))) begin
                    d.eng_rst = 1'b1;
                    d.state   = S_RST;
                end else begin
                    if (is_defer || count_bad) d.err = ERR_REMOTE;
                    else if (q.r_cmd[0])       d.rdata = eng_rdata;
                    d.claim = 1'b0;
                    d.state = S_REL;
                end
            end
            S_REL: begin
                if (claim_grant) d.err = ERR_IO;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETTLE_CYC);
                d.state  = S_TAIL;
            end
            S_TAIL: if (tmr_exp) begin
                d.done  = 1'b1;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.err   <= ERR_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.state != S_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign reply     = q.reply;
    assign rdata     = q.rdata;
    assign claim_req = q.claim;
    assign eng_rst   = q.eng_rst;
    assign eng_trig  = q.eng_trig;
    assign eng_cmd   = q.eng_cmd;
    assign eng_addr  = q.eng_addr;
    assign eng_len   = q.eng_len;
    assign eng_wdata = q.eng_wdata;
endmodule

// File: rtl/aux_txn_seq_chk.sv
`timescale 1ns/1ps
module aux_txn_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic claim_req,
    input logic eng_rst,
    input logic eng_trig
);
    assert_strobe_claimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rst || eng_trig) |-> claim_req)
        else $error("strobe outside claim");

    assert_rst_trig_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst |-> !eng_trig)
        else $error("reset and trigger together");

    assert_trig_after_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_trig) |-> $past(eng_rst))
        else $error("trigger without preceding reset pulse");

    assert_released_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !claim_req)
        else $error("claim held at done");

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    assert_claim_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claim_req) |-> ($past(start) && !$past(busy)))
        else $error("claim without idle start");
endmodule

bind aux_txn_seq aux_txn_seq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .claim_req (claim_req),
    .eng_rst   (eng_rst),
    .eng_trig  (eng_trig)
);

// File: tb/test_aux_txn_seq.sv
`timescale 1ns/1ps
module test_aux_txn_seq;
    localparam int SETTLE = 400;
    localparam logic [127:0] RPAT = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;

    typedef struct packed {
        logic [3:0] cmd;
        logic [4:0] n;
        logic [4:0] defer;
        logic [3:0] fin;
        logic [4:0] rcnt;
        logic       g;
        logic       r;
        logic       a;
        logic [1:0] eerr;
        logic [3:0] erep;
        logic [4:0] erst;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{4'd8, 5'd1,  5'd0,  4'd0, 5'd0,  1'b1, 1'b1, 1'b1, 2'd0, 4'd0, 5'd1 },
        '{4'd9, 5'd4,  5'd0,  4'd0, 5'd4,  1'b1, 1'b1, 1'b1, 2'd0, 4'd0, 5'd1 },
        '{4'd8, 5'd3,  5'd3,  4'd0, 5'd0,  1'b1, 1'b1, 1'b1, 2'd0, 4'd0, 5'd4 },
        '{4'd9, 5'd16, 5'd15, 4'd0, 5'd16, 1'b1, 1'b1, 1'b1, 2'd0, 4'd0, 5'd16},
        '{4'd8, 5'd2,  5'd16, 4'd0, 5'd0,  1'b1, 1'b1, 1'b1, 2'd3, 4'd2, 5'd16},
        '{4'd9, 5'd2,  5'd0,  4'd0, 5'd3,  1'b1, 1'b1, 1'b1, 2'd3, 4'd0, 5'd1 },
        '{4'd8, 5'd1,  5'd0,  4'd1, 5'd0,  1'b1, 1'b1, 1'b1, 2'd0, 4'd1, 5'd1 },
        '{4'd8, 5'd1,  5'd0,  4'd0, 5'd0,  1'b0, 1'b1, 1'b1, 2'd1, 4'd0, 5'd0 },
        '{4'd8, 5'd1,  5'd0,  4'd0, 5'd0,  1'b1, 1'b0, 1'b1, 2'd2, 4'd0, 5'd0 },
        '{4'd8, 5'd1,  5'd0,  4'd0, 5'd0,  1'b1, 1'b1, 1'b0, 2'd2, 4'd0, 5'd1 }
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] cmd = '0;
    logic [19:0] addr = '0;
    logic [4:0] nbytes = 5'd1;
    logic [127:0] wdata = '0;
    logic busy, done, claim_req, claim_grant, eng_ready, eng_rst, eng_trig, eng_trig_ack;
    logic [1:0] err;
    logic [3:0] reply, eng_cmd, eng_len;
    logic [127:0] rdata, eng_wdata;
    logic [19:0] eng_addr;
    logic [3:0] eng_reply;
    logic [4:0] eng_rcount = '0;

    logic grant_en = 1'b1, grant_stuck = 1'b0, ready_en = 1'b1, ack_en = 1'b1, clr = 1'b0;
    logic [4:0] defer_n = '0;
    logic [3:0] fin_reply = '0;
    int rst_cnt, trig_cnt;
    int total = 0, bad = 0, cycles = 0;

    always #10 clk = ~clk;

    assign claim_grant  = grant_stuck | (claim_req & grant_en);
    assign eng_ready    = ready_en;
    assign eng_trig_ack = eng_trig & ack_en;

    always @(posedge clk) begin
        if (clr) begin
            rst_cnt   <= 0;
            trig_cnt  <= 0;
            eng_reply <= '0;
        end else begin
            if (eng_rst) rst_cnt <= rst_cnt + 1;
            if (eng_trig && eng_trig_ack) begin
                eng_reply <= (trig_cnt < int'(defer_n)) ? 4'd2 : fin_reply;
                trig_cnt  <= trig_cnt + 1;
            end
        end
    end

    aux_txn_seq #(.CLK_MHZ(1), .POLL_US(100), .SETTLE_US(SETTLE), .TRIG_TIMEOUT(64)) i_aux_txn_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .nbytes(nbytes),
        .wdata(wdata), .busy(busy), .done(done), .err(err), .reply(reply), .rdata(rdata),
        .claim_req(claim_req), .claim_grant(claim_grant), .eng_ready(eng_ready),
        .eng_rst(eng_rst), .eng_trig(eng_trig), .eng_trig_ack(eng_trig_ack),
        .eng_cmd(eng_cmd), .eng_addr(eng_addr), .eng_len(eng_len), .eng_wdata(eng_wdata),
        .eng_reply(eng_reply), .eng_rcount(eng_rcount), .eng_rdata(RPAT)
    );

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 200000) begin
                chk(1'b0, "watchdog", 128'(cycles), 128'd200000);
                finish_run();
            end
        end
    end

    // Start a transaction and wait for done; returns cycles taken.
    task automatic run_txn(output int dur, output logic [1:0] r_err, output logic [3:0] r_rep,
                           output logic [127:0] r_data);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        dur = 1;
        while (!done && dur < 30000) begin
            @(negedge clk);
            dur++;
        end
        chk(done, "done pulse R10", 128'(done), 128'd1);
        r_err = err; r_rep = reply; r_data = rdata;
        @(negedge clk);
        chk(!done, "done single R10", 128'(done), 128'd0);
    endtask

    initial begin
        int dur;
        logic [1:0] e;
        logic [3:0] rp;
        logic [127:0] rd;
        logic [127:0] last_w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !claim_req && !eng_trig && !eng_rst, "reset idle R10",
            128'({busy, done, claim_req, eng_trig, eng_rst}), 128'd0);
        chk(err == 2'd0 && rdata == '0, "reset outputs R10", rdata, 128'd0);
        last_w = '0;

        for (int i = 0; i < 10; i++) begin
            cmd = VEC[i].cmd; nbytes = VEC[i].n; defer_n = VEC[i].defer;
            fin_reply = VEC[i].fin; eng_rcount = VEC[i].rcnt;
            grant_en = VEC[i].g; ready_en = VEC[i].r; ack_en = VEC[i].a;
            addr = 20'(i * 4099 + 5);
            wdata = {16{8'(i * 17 + 3)}};
            run_txn(dur, e, rp, rd);
            chk(e == VEC[i].eerr, $sformatf("vec%0d err R1 R2 R5 R7 R8", i), 128'(e), 128'(VEC[i].eerr));
            chk(rp == VEC[i].erep, $sformatf("vec%0d reply R6 R10", i), 128'(rp), 128'(VEC[i].erep));
            chk(rst_cnt == int'(VEC[i].erst), $sformatf("vec%0d attempts R5 R6", i),
                128'(rst_cnt), 128'(VEC[i].erst));
            chk(rd == ((VEC[i].eerr == 2'd0 && VEC[i].cmd[0]) ? RPAT : 128'd0),
                $sformatf("vec%0d rdata R8", i), rd,
                (VEC[i].eerr == 2'd0 && VEC[i].cmd[0]) ? RPAT : 128'd0);
            chk(!claim_req, $sformatf("vec%0d released R9", i), 128'(claim_req), 128'd0);
            if (VEC[i].erst != 0) begin
                chk(eng_addr == addr && eng_cmd == cmd, $sformatf("vec%0d addr/cmd R4", i),
                    128'({eng_addr, eng_cmd}), 128'({addr, cmd}));
                chk(eng_len == 4'(VEC[i].n - 1), $sformatf("vec%0d len R4", i),
                    128'(eng_len), 128'(VEC[i].n - 1));
                if (!cmd[0]) last_w = wdata;
                chk(eng_wdata == last_w, $sformatf("vec%0d wdata R3", i), eng_wdata, last_w);
            end
            if (i == 0)
                chk(dur >= 2 * SETTLE, "settle+tail duration R9", 128'(dur), 128'(2 * SETTLE));
        end

        // Grant never clears after release.
        grant_en = 1'b1; ready_en = 1'b1; ack_en = 1'b1; defer_n = '0; fin_reply = '0;
        cmd = 4'd8; grant_stuck = 1'b1;
        run_txn(dur, e, rp, rd);
        grant_stuck = 1'b0;
        chk(e == 2'd1, "stuck grant io R9", 128'(e), 128'd1);

        // Start while busy is ignored.
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        cmd = 4'd8; addr = 20'h12345; nbytes = 5'd2; wdata = {16{8'h5A}}; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        cmd = 4'd9; addr = 20'h0ABCD; nbytes = 5'd7; start = 1'b1;
        @(negedge clk); start = 1'b0;
        dur = 0;
        while (!done && dur < 30000) begin
            @(negedge clk);
            dur++;
        end
        chk(done && err == 2'd0, "first txn completes R11", 128'({done, err}), 128'd4);
        chk(eng_addr == 20'h12345 && eng_cmd == 4'd8 && eng_len == 4'd1, "busy start ignored R11",
            128'({eng_addr, eng_cmd, eng_len}), 128'({20'h12345, 4'd8, 4'd1}));
        chk(rst_cnt == 1, "one attempt only R11", 128'(rst_cnt), 128'd1);
        repeat (30) @(negedge clk);
        chk(!busy && !claim_req, "no second txn R11", 128'({busy, claim_req}), 128'd0);

        finish_run();
    end
endmodule